// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Data Latch

This block is the digital front end of a two-channel, 14-bit current-steering converter. Each channel owns a parallel data port, a write strobe and an update strobe. A word travels through two registers per channel. The first is an input register, loaded when the write strobe rises. On the falling edge of the same strobe, the input register's contents become the presented value. When the update strobe next rises, the presented value moves into the converter register. The converter register drives the output code and its complement.

The strobes and the power-down request arrive asynchronously to a fast system clock. Each passes through a synchronizer chain, and edges are found by comparing each synchronized sample with the one before it. While power-down is active, the converter register holds its value and ignores update edges. Writes still go through, so the first update after power-down ends delivers the newest word. Each channel also watches the order of its strobes. A write that rises with no update rise since the previous write fall sets a sticky ordering flag, which a per-channel clear input removes. The update and write strobes may be tied together.

Top module: `dual_dac_latch`

## Requirements
- R1: The two channels are independent. Strobes, data and clear on one channel never change the other channel's code, complement or ordering flag.
- R2: Data coding is straight binary, with bit 13 as the MSB. When a write rising edge is detected, the channel's data port (bits c*14+13 down to c*14 of `data_in`) is loaded into the input register.
- R3: A write falling edge presents the input register. An update rising edge copies the presented value to `code_out`. The output changes on the third rising clock edge after the strobe level change, counting the edge that first samples it as the first. Only an update rising edge while power-down is inactive changes the code.
- R4: With the write and update strobes tied together, each strobe pulse outputs the word captured by the previous pulse.
- R5: `code_cmp_out` equals 16383 minus `code_out` for each channel: 0x3FFF gives 0, 0x2000 gives 0x1FFF, and 0x0000 gives 0x3FFF.
- R6: `pwr_down` reaches `pd_flag` (all bits) on the second rising clock edge after it changes. While the synchronized power-down is high, the converter register holds its value. Writes continue, and the first update after release outputs the latest presented word.
- R7: `order_err` is set when a write rising edge is detected and no update rising edge has been seen since the previous write falling edge, or at the same sample. An update rise in the same sample as a write fall counts as coming after that fall. The flag is sticky. `viol_clr` clears it on the next clock edge, and the clear wins over a simultaneous set.
- R8: Synchronous reset sets the input, presented and converter registers of both channels to 0x2000 and clears the ordering flags and `pd_flag`. The first write after reset does not set `order_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | 28 | Data ports; channel c uses bits c*14+13 down to c*14 |
| wr_stb | input | 2 | Write strobe per channel (asynchronous) |
| upd_stb | input | 2 | Update strobe per channel (asynchronous) |
| pwr_down | input | 1 | Power-down request, high = power-down |
| viol_clr | input | 2 | Synchronous clear of the ordering flag per channel |
| code_out | output | 28 | Held converter code per channel |
| code_cmp_out | output | 28 | Complementary code per channel |
| pd_flag | output | 2 | Synchronized power-down state per channel |
| order_err | output | 2 | Sticky strobe-ordering violation per channel |

## Verification
A strobe level change reaches the code and the ordering flag on the third clock edge after it is first sampled. Power-down reaches its flag on the second edge. The bench model applies the same per-edge latencies to its own sample history, which is updated at each rising edge, and compares every output at the falling edge of each cycle. Directed checks sample only after a strobe pulse has fully settled, at least five cycles after its last level change, and compare against hard-coded values taken from the requirements.

// File: rtl/dacl_pkg.sv
package dacl_pkg;
   function automatic int unsigned mid_code(input int unsigned width);
      return 32'd1 << (width - 1);
   endfunction
endpackage

// File: rtl/dacl_sync.sv
module dacl_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] async_in,
   output logic [W-1:0] sync_out
);
   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= async_in;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign sync_out = stg[STAGES-1];
endmodule

// File: rtl/dacl_hist.sv
module dacl_hist #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] cur,
   output logic [W-1:0] prev
);
   always_ff @(posedge clk) begin
      if (rst) prev <= '0;
      else     prev <= cur;
   end
endmodule

// File: rtl/dacl_chan.sv
module dacl_chan #(
   parameter int DATA_W = 14
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] din,
   input  logic              wr_now,
   input  logic              wr_prev,
   input  logic              upd_now,
   input  logic              upd_prev,
   input  logic              pd_s,
   input  logic              clr,
   output logic [DATA_W-1:0] code,
   output logic [DATA_W-1:0] code_n,
   output logic              err
);
   localparam logic [DATA_W-1:0] MID = DATA_W'(dacl_pkg::mid_code(DATA_W));

   logic wr_rise, wr_fall, upd_rise;
   logic [DATA_W-1:0] in_q, pres_q, conv_q;
   logic upd_seen, err_q;

   assign wr_rise  = wr_now & ~wr_prev;
   assign wr_fall  = ~wr_now & wr_prev;
   assign upd_rise = upd_now & ~upd_prev;

   always_ff @(posedge clk) begin
      if (rst) begin
         in_q     <= MID;
         pres_q   <= MID;
         conv_q   <= MID;
         upd_seen <= 1'b1;
         err_q    <= 1'b0;
      end else begin
         if (wr_rise) in_q <= din;
         if (wr_fall) pres_q <= in_q;
         if (upd_rise && !pd_s) conv_q <= pres_q;
         if (wr_fall)       upd_seen <= upd_rise;
         else if (upd_rise) upd_seen <= 1'b1;
         if (clr) err_q <= 1'b0;
         else if (wr_rise && !(upd_seen || upd_rise)) err_q <= 1'b1;
      end
   end

   assign code   = conv_q;
   assign code_n = ~conv_q;
   assign err    = err_q;

   AST_CAPTURE_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
      wr_rise |=> (in_q == $past(din)));                           // R2
   AST_LOAD_ON_UPDATE: assert property (@(posedge clk) disable iff (rst)
      (upd_rise && !pd_s) |=> (conv_q == $past(pres_q)));           // R3
   AST_HOLD_WITHOUT_UPDATE: assert property (@(posedge clk) disable iff (rst)
      !upd_rise |=> $stable(conv_q));                               // R3
   AST_FREEZE_IN_POWER_DOWN: assert property (@(posedge clk) disable iff (rst)
      pd_s |=> $stable(conv_q));                                    // R6
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
      (err_q && !clr) |=> err_q);                                   // R7
   AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
      clr |=> !err_q);                                              // R7
endmodule

// File: rtl/dual_dac_latch.sv
module dual_dac_latch #(
   parameter int NUM_CH      = 2,
   parameter int DATA_W      = 14,
   parameter int SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [NUM_CH*DATA_W-1:0] data_in,
   input  logic [NUM_CH-1:0]        wr_stb,
   input  logic [NUM_CH-1:0]        upd_stb,
   input  logic                     pwr_down,
   input  logic [NUM_CH-1:0]        viol_clr,
   output logic [NUM_CH*DATA_W-1:0] code_out,
   output logic [NUM_CH*DATA_W-1:0] code_cmp_out,
   output logic [NUM_CH-1:0]        pd_flag,
   output logic [NUM_CH-1:0]        order_err
);
   localparam int STB_W = 2 * NUM_CH;

   initial begin
      if (NUM_CH < 1)          $error("NUM_CH must be at least 1");
      if (DATA_W < 2)          $error("DATA_W must be at least 2");
      if (SYNC_STAGES < 2)     $error("SYNC_STAGES must be at least 2");
   end

   logic [STB_W-1:0] stb_raw, stb_s, stb_p;
   logic             pd_s;

   assign stb_raw = {upd_stb, wr_stb};

   dacl_sync #(.W(STB_W), .STAGES(SYNC_STAGES)) u_stb_sync (
      .clk(clk), .rst(rst), .async_in(stb_raw), .sync_out(stb_s));

   dacl_sync #(.W(1), .STAGES(SYNC_STAGES)) u_pd_sync (
      .clk(clk), .rst(rst), .async_in(pwr_down), .sync_out(pd_s));

   dacl_hist #(.W(STB_W)) u_hist (
      .clk(clk), .rst(rst), .cur(stb_s), .prev(stb_p));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      dacl_chan #(.DATA_W(DATA_W)) u_chan (
         .clk      (clk),
         .rst      (rst),
         .din      (data_in[c*DATA_W +: DATA_W]),
         .wr_now   (stb_s[c]),
         .wr_prev  (stb_p[c]),
         .upd_now  (stb_s[NUM_CH+c]),
         .upd_prev (stb_p[NUM_CH+c]),
         .pd_s     (pd_s),
         .clr      (viol_clr[c]),
         .code     (code_out[c*DATA_W +: DATA_W]),
         .code_n   (code_cmp_out[c*DATA_W +: DATA_W]),
         .err      (order_err[c]));
      assign pd_flag[c] = pd_s;
   end
endmodule

// File: tb/dual_dac_latch_test.sv
module dual_dac_latch_test;
   localparam int NC = 2;
   localparam int DW = 14;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [NC*DW-1:0] data_in = '0;
   logic [NC-1:0] wr_stb = '0, upd_stb = '0, viol_clr = '0;
   logic pwr_down = 1'b0;
   logic [NC*DW-1:0] code_out, code_cmp_out;
   logic [NC-1:0] pd_flag, order_err;

   int checks = 0, failures = 0, cycles = 0;

   always #2 clk = ~clk;

   dual_dac_latch uut (.clk(clk), .rst(rst), .data_in(data_in), .wr_stb(wr_stb),
      .upd_stb(upd_stb), .pwr_down(pwr_down), .viol_clr(viol_clr), .code_out(code_out),
      .code_cmp_out(code_cmp_out), .pd_flag(pd_flag), .order_err(order_err));

   // behavioural reference model
   int w1[NC], w2[NC], w3[NC], u1[NC], u2[NC], u3[NC];
   int inreg[NC], pres[NC], conv[NC], seen[NC], err[NC];
   int p1, p2;

   always @(posedge clk) begin
      if (rst) begin
         for (int c = 0; c < NC; c++) begin
            w1[c] = 0; w2[c] = 0; w3[c] = 0; u1[c] = 0; u2[c] = 0; u3[c] = 0;
            inreg[c] = 8192; pres[c] = 8192; conv[c] = 8192; seen[c] = 1; err[c] = 0;
         end
         p1 = 0; p2 = 0;
      end else begin
         for (int c = 0; c < NC; c++) begin
            bit wr_r, wr_f, up_r;
            int old_in, old_pres;
            wr_r = (w2[c] == 1) && (w3[c] == 0);
            wr_f = (w2[c] == 0) && (w3[c] == 1);
            up_r = (u2[c] == 1) && (u3[c] == 0);
            old_in = inreg[c]; old_pres = pres[c];
            if (wr_r) inreg[c] = int'(data_in[c*DW +: DW]);
            if (wr_f) pres[c] = old_in;
            if (up_r && p2 == 0) conv[c] = old_pres;
            if (viol_clr[c]) err[c] = 0;
            else if (wr_r && seen[c] == 0 && !up_r) err[c] = 1;
            if (wr_f) seen[c] = up_r ? 1 : 0;
            else if (up_r) seen[c] = 1;
            w3[c] = w2[c]; w2[c] = w1[c]; w1[c] = int'(wr_stb[c]);
            u3[c] = u2[c]; u2[c] = u1[c]; u1[c] = int'(upd_stb[c]);
         end
         p2 = p1; p1 = int'(pwr_down);
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      cycles++;
      if (!rst && cycles > 3) begin
         for (int c = 0; c < NC; c++) begin
            chk("R3 model code", int'(code_out[c*DW +: DW]), conv[c]);
            chk("R5 model complement", int'(code_cmp_out[c*DW +: DW]), 16383 - conv[c]);
            chk("R6 model pd_flag", int'(pd_flag[c]), p2);
            chk("R7 model order_err", int'(order_err[c]), err[c]);
         end
      end
      if (cycles > 20000) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=<20000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic wait_n(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse(input int c, input int val, input bit do_wr, input bit do_up);
      @(negedge clk);
      data_in[c*DW +: DW] = DW'(val);
      wait_n(1);
      if (do_wr) wr_stb[c] = 1'b1;
      if (do_up) upd_stb[c] = 1'b1;
      wait_n(5);
      wr_stb[c] = 1'b0; upd_stb[c] = 1'b0;
      wait_n(5);
   endtask

   function automatic int code_of(input int c);
      return int'(code_out[c*DW +: DW]);
   endfunction
   function automatic int cmp_of(input int c);
      return int'(code_cmp_out[c*DW +: DW]);
   endfunction

   initial begin
      wait_n(4);
      rst = 1'b0;
      wait_n(1);
      // R8 reset state
      chk("R8 reset code ch0", code_of(0), 16'h2000);
      chk("R8 reset code ch1", code_of(1), 16'h2000);
      chk("R5 mid complement", cmp_of(0), 16'h1FFF);
      chk("R8 reset order_err", int'(order_err), 0);

      // R4 tied strobes: output lags one pulse
      pulse(0, 16'h3FFF, 1, 1);
      chk("R4 first tied pulse outputs reset word", code_of(0), 16'h2000);
      chk("R8 first write no violation", int'(order_err[0]), 0);
      pulse(0, 16'h0000, 1, 1);
      chk("R4 second pulse outputs 0x3FFF", code_of(0), 16'h3FFF);
      chk("R5 full-scale complement", cmp_of(0), 0);
      pulse(0, 16'h1234, 1, 1);
      chk("R2 R4 zero code", code_of(0), 0);
      chk("R5 zero complement", cmp_of(0), 16'h3FFF);
      chk("R1 ch1 untouched", code_of(1), 16'h2000);

      // R3 separate strobes: write only, then update only
      pulse(1, 16'h2ABC, 1, 0);
      chk("R3 write alone leaves code", code_of(1), 16'h2000);
      pulse(1, 16'h0001, 0, 1);
      chk("R3 R2 update loads presented word", code_of(1), 16'h2ABC);
      pulse(1, 16'h0002, 0, 1);
      chk("R3 repeat update same word", code_of(1), 16'h2ABC);

      // R7 violation: two writes without update
      pulse(1, 16'h0111, 1, 0);
      chk("R7 ordered write no flag", int'(order_err[1]), 0);
      pulse(1, 16'h0222, 1, 0);
      chk("R7 flag set", int'(order_err[1]), 1);
      chk("R1 ch0 flag unaffected", int'(order_err[0]), 0);
      pulse(1, 16'h0003, 0, 1);
      chk("R7 flag sticky", int'(order_err[1]), 1);
      @(negedge clk); viol_clr[1] = 1'b1;
      @(negedge clk); viol_clr[1] = 1'b0;
      chk("R7 flag cleared", int'(order_err[1]), 0);

      // R6 power-down
      pulse(0, 16'h0AAA, 1, 1);
      @(negedge clk); pwr_down = 1'b1;
      wait_n(1);
      chk("R6 flag not yet", int'(pd_flag), 0);
      wait_n(1);
      chk("R6 flag after two edges", int'(pd_flag), 3);
      begin
         int held;
         held = code_of(0);
         pulse(0, 16'h0BBB, 1, 1);
         pulse(0, 16'h0CCC, 1, 1);
         chk("R6 code frozen", code_of(0), held);
         @(negedge clk); pwr_down = 1'b0;
         wait_n(4);
         chk("R6 frozen until update", code_of(0), held);
         pulse(0, 16'h0DDD, 0, 1);
         chk("R6 latest word after release", code_of(0), 16'h0CCC);
      end
      wait_n(3);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule